// File: doc/BRIEF.md
# Programmable Chip-Select Timing Controller

This block is one bank of a bus-side memory controller. A host presents a byte address, a direction bit and write data with a single-cycle request. The bank compares the upper address bits with a programmed base address, keeping only the bit positions enabled by a programmed mask. If the bank is valid, the compare succeeds and the bank is assigned to this controller, it drives a peripheral access: register address lines, a read/write direction line, write data with its output enable, and an active-low chip select.

All timing is counted on a clock that runs at four times the peripheral bus rate, so each clock is one quarter of a bus cycle. A setup code delays the chip select behind the address by zero, one or two quarters. A cycle-length field holds the chip select for a whole number of bus cycles. In the normal mode the access ends when that count runs out and the peripheral acknowledge is ignored. A bypass bit lets the acknowledge end the access instead. At the end the chip select and direction line return to idle, read data is captured, and the host gets a one-cycle done pulse. A request that no valid bank claims gets a done pulse with an error flag and never touches the chip select.

Top module: `cs_timing_ctrl`

## Requirements
- R1: Out of reset, cs_n_o and dir_o are high, and done_o, err_o and dev_dq_oe_o are low.
- R2: A request hits only when base bit 0 (valid) is 1 and addr_i[31:15] equals base[31:15] in every bit position where opt[31:15] holds a 1. Mask positions holding 0 are ignored.
- R3: The machine-select field base[8:6] must equal 3'b001 for a hit. Every other code is treated as a miss.
- R4: A missed request raises done_o and err_o together for exactly one clock, on the clock after the request is taken, and cs_n_o stays high.
- R5: Address, direction and write data take their values on the clock after the request is taken. The setup code opt[10:9] sets the delay before cs_n_o falls: 2'b10 is one clock, 2'b11 is two clocks, and 2'b00 or 2'b01 is none.
- R6: With the bypass bit opt[3] at 0, cs_n_o stays low for exactly 4*(N+1) clocks, where N is opt[7:4].
- R7: done_o is high for exactly one clock, in the first clock that cs_n_o is high again, with err_o low.
- R8: With opt[3] at 0, dev_ack_n_i has no effect on the length of the access.
- R9: With opt[3] at 1, the access ends on the first clock edge, after cs_n_o has fallen, at which dev_ack_n_i is low.
- R10: dev_addr_o is set by the port-size field base[12:11]: 2'b11 (32-bit) gives addr_i[4:2], 2'b10 (16-bit) gives addr_i[3:1], and any other code gives addr_i[2:0].
- R11: dir_o is 0 for a write and 1 for a read, and it holds together with dev_addr_o while cs_n_o is low. A write drives wdata_i on dev_dq_o with dev_dq_oe_o high. A read leaves dev_dq_oe_o low and returns dev_dq_i, sampled at the closing edge, on rdata_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Quarter-bus-cycle clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, taken while idle |
| rd_i | input | 1 | 1 for read, 0 for write |
| addr_i | input | 32 | Host byte address |
| wdata_i | input | 32 | Host write data |
| base_i | input | 32 | Base configuration word |
| opt_i | input | 32 | Option configuration word |
| rdata_o | output | 32 | Captured read data |
| done_o | output | 1 | One-cycle access-complete pulse |
| err_o | output | 1 | Set with done_o when no bank claimed the request |
| cs_n_o | output | 1 | Active-low peripheral chip select |
| dir_o | output | 1 | Direction line, low for write |
| dev_addr_o | output | 3 | Peripheral register address |
| dev_dq_o | output | 32 | Write data toward the peripheral |
| dev_dq_oe_o | output | 1 | Output enable for dev_dq_o |
| dev_dq_i | input | 32 | Read data from the peripheral |
| dev_ack_n_i | input | 1 | Active-low peripheral acknowledge |

## Verification
The bench sweeps every setup code against several cycle lengths, both directions and both wide port sizes. This separates an off-by-one in the setup delay from an off-by-one in the strobe length, and it catches address-slice errors because the low address bits change on every access. A second group varies the valid bit, every machine-select code and masked versus unmasked address differences, which separates a decode that ignores the mask from one that ignores the base. A final group pulls the acknowledge low both early and late, with the bypass bit cleared and with it set. This shows that a counted access does not react to the acknowledge, and that an acknowledge-ended access never ends during setup.

// File: rtl/cs_timing_ctrl.sv
module cs_timing_ctrl #(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int BA_W   = 17,
  parameter int DEV_AW = 3,
  parameter int CYC_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              rd_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [31:0]       base_i,
  input  logic [31:0]       opt_i,
  output logic [DW-1:0]     rdata_o,
  output logic              done_o,
  output logic              err_o,
  output logic              cs_n_o,
  output logic              dir_o,
  output logic [DEV_AW-1:0] dev_addr_o,
  output logic [DW-1:0]     dev_dq_o,
  output logic              dev_dq_oe_o,
  input  logic [DW-1:0]     dev_dq_i,
  input  logic              dev_ack_n_i
);

  localparam int WIN_LSB = AW - BA_W;
  localparam int CNT_W   = CYC_W + 3;
  localparam int PS_LSB  = 11;
  localparam int MS_LSB  = 6;
  localparam int ACS_LSB = 9;
  localparam int SCY_LSB = 4;
  localparam int EXT_BIT = 3;
  localparam logic [2:0] MS_SELF = 3'b001;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STROBE} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt, tot_r;
  logic             ext_r;

  logic [BA_W-1:0]   diff;
  logic              hit;
  logic [1:0]        acs, ps;
  logic [CNT_W-1:0]  setup_q, tot_q;
  logic [DEV_AW-1:0] dev_addr_nx;

  assign diff  = (addr_i[AW-1:WIN_LSB] ^ base_i[31:32-BA_W]) & opt_i[31:32-BA_W];
  assign hit   = base_i[0] && (base_i[MS_LSB+2:MS_LSB] == MS_SELF) && (diff == '0);
  assign acs   = opt_i[ACS_LSB+1:ACS_LSB];
  assign ps    = base_i[PS_LSB+1:PS_LSB];
  assign tot_q = ({{(CNT_W-CYC_W){1'b0}}, opt_i[SCY_LSB+CYC_W-1:SCY_LSB]} + CNT_W'(1)) << 2;

  always_comb begin
    case (acs)
      2'b10:   setup_q = CNT_W'(1);
      2'b11:   setup_q = CNT_W'(2);
      default: setup_q = '0;
    endcase
    case (ps)
      2'b11:   dev_addr_nx = addr_i[DEV_AW+1:2];
      2'b10:   dev_addr_nx = addr_i[DEV_AW:1];
      default: dev_addr_nx = addr_i[DEV_AW-1:0];
    endcase
  end

  logic unused_cfg;
  assign unused_cfg = ^{base_i[14:13], base_i[10:9], base_i[5:1],
                        opt_i[14:11], opt_i[8], opt_i[2:0], addr_i[14:5]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      tot_r       <= '0;
      ext_r       <= 1'b0;
      cs_n_o      <= 1'b1;
      dir_o       <= 1'b1;
      dev_addr_o  <= '0;
      dev_dq_o    <= '0;
      dev_dq_oe_o <= 1'b0;
      rdata_o     <= '0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      case (st)
        S_IDLE: if (req_i) begin
          if (hit) begin
            dev_addr_o  <= dev_addr_nx;
            dir_o       <= rd_i;
            dev_dq_oe_o <= !rd_i;
            dev_dq_o    <= wdata_i;
            ext_r       <= opt_i[EXT_BIT];
            tot_r       <= tot_q;
            if (setup_q == '0) begin
              cs_n_o <= 1'b0;
              cnt    <= tot_q - CNT_W'(1);
              st     <= S_STROBE;
            end else begin
              cnt <= setup_q - CNT_W'(1);
              st  <= S_SETUP;
            end
          end else begin
            done_o <= 1'b1;
            err_o  <= 1'b1;
          end
        end
        S_SETUP: begin
          if (cnt == '0) begin
            cs_n_o <= 1'b0;
            cnt    <= tot_r - CNT_W'(1);
            st     <= S_STROBE;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        S_STROBE: begin
          if (ext_r ? !dev_ack_n_i : (cnt == '0)) begin
            cs_n_o      <= 1'b1;
            dir_o       <= 1'b1;
            dev_dq_oe_o <= 1'b0;
            done_o      <= 1'b1;
            if (dir_o) rdata_o <= dev_dq_i;
            st <= S_IDLE;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7
  AST_MISS_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (cs_n_o && done_o)); // R4
  AST_SETUP_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SETUP) |-> cs_n_o); // R5
  AST_STROBE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && $past(!cs_n_o)) |-> ($stable(dev_addr_o) && $stable(dir_o))); // R11
  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && !dir_o) |-> dev_dq_oe_o); // R11
  AST_DONE_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> (cs_n_o && $past(!cs_n_o))); // R7
  AST_COUNTED_IGNORES_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_STROBE) && !ext_r && (cnt != '0)) |=> !cs_n_o); // R8

endmodule

// File: tb/tb_cs_timing_ctrl.sv
module tb_cs_timing_ctrl;
  logic        clk = 0, rst_n = 0;
  logic        req = 0, rd = 0, ack_n = 1;
  logic [31:0] addr = 0, wdata = 0, base = 0, opt = 0, dq_in = 0;
  logic [31:0] rdata, dq_out;
  logic        done, err, cs_n, dir, oe;
  logic [2:0]  dev_addr;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cs_timing_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .base_i(base), .opt_i(opt), .rdata_o(rdata),
    .done_o(done), .err_o(err), .cs_n_o(cs_n), .dir_o(dir),
    .dev_addr_o(dev_addr), .dev_dq_o(dq_out), .dev_dq_oe_o(oe),
    .dev_dq_i(dq_in), .dev_ack_n_i(ack_n));

  localparam logic [16:0] BA = 17'h1A2B3;

  function automatic logic [31:0] mk_base(logic [16:0] b, logic [1:0] ps, logic [2:0] ms, logic v);
    return {b, 2'b00, ps, 2'b00, ms, 5'b0, v};
  endfunction

  function automatic logic [31:0] mk_opt(logic [16:0] m, logic [1:0] acs, logic [3:0] scy, logic ext);
    return {m, 4'b0, acs, 1'b0, scy, ext, 3'b0};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ack_k: negedge index at which ack is pulled low (0 = never)
  task automatic access(input logic [31:0] b, input logic [31:0] o, input logic [31:0] a,
                        input logic r, input int ack_k, input string tag);
    bit        hit;
    int        s, tot, end_e, first_cs, last_cs, done_k;
    logic      err_s, dir_s, oe_s;
    logic [2:0]  da_s, exp_da;
    logic [31:0] dq_s, exp_rd;
    hit = b[0] && (b[8:6] == 3'b001) && (((a[31:15] ^ b[31:15]) & o[31:15]) == 0);
    s   = (o[10:9] == 2'b10) ? 1 : (o[10:9] == 2'b11) ? 2 : 0;
    tot = 4 * (int'(o[7:4]) + 1);
    if (o[3]) end_e = (ack_k > s + 1) ? ack_k : s + 1;
    else      end_e = s + tot;
    case (b[12:11])
      2'b11:   exp_da = a[4:2];
      2'b10:   exp_da = a[3:1];
      default: exp_da = a[2:0];
    endcase
    exp_rd = 32'hC0DE0000 ^ a;
    base = b; opt = o; addr = a; rd = r; wdata = ~a; dq_in = exp_rd;
    first_cs = 0; last_cs = 0; done_k = 0; err_s = 0;
    dir_s = 0; oe_s = 0; da_s = 0; dq_s = 0;
    @(negedge clk); req = 1;
    for (int k = 1; k <= 400; k++) begin
      @(negedge clk);
      req = 0;
      if (ack_k > 0 && k == ack_k) ack_n = 0;
      if (!cs_n) begin
        if (first_cs == 0) begin
          first_cs = k; dir_s = dir; oe_s = oe; da_s = dev_addr; dq_s = dq_out;
        end
        last_cs = k;
      end
      if (done) begin done_k = k; err_s = err; break; end
    end
    ack_n = 1;
    if (done_k == 0) begin
      checks++; fails++;
      $display("FAIL %s watchdog: no done actual=0 expected=1", tag);
      return;
    end
    if (!hit) begin
      chk(done_k == 1, {tag, " R4 done timing"}, done_k, 1);
      chk(err_s == 1, {tag, " R4 err"}, err_s, 1);
      chk(first_cs == 0, {tag, " R2 R3 no cs"}, first_cs, 0);
    end else begin
      chk(first_cs == s + 1, {tag, " R5 cs delay"}, first_cs, s + 1);
      chk(last_cs == end_e, {tag, o[3] ? " R9 ack end" : " R6 R8 strobe len"}, last_cs, end_e);
      chk(done_k == end_e + 1, {tag, " R7 done timing"}, done_k, end_e + 1);
      chk(err_s == 0, {tag, " R7 no err"}, err_s, 0);
      chk(da_s == exp_da, {tag, " R10 dev addr"}, da_s, exp_da);
      chk(dir_s == r, {tag, " R11 dir"}, dir_s, r);
      chk(oe_s == !r, {tag, " R11 oe"}, oe_s, !r);
      if (r) chk(rdata == exp_rd, {tag, " R11 rdata"}, rdata, exp_rd);
      else   chk(dq_s == ~a, {tag, " R11 wdata"}, dq_s, ~a);
    end
    @(negedge clk);
    chk(cs_n && !done, {tag, " R7 idle after"}, {cs_n, done}, 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1, "R1 cs_n", cs_n, 1);
    chk(dir == 1, "R1 dir", dir, 1);
    chk(done == 0 && err == 0, "R1 done/err", {done, err}, 0);
    chk(oe == 0, "R1 oe", oe, 0);
    rst_n = 1;
    @(negedge clk);

    // timing and mapping sweep
    for (int ac = 0; ac < 4; ac++)
      for (int sc = 0; sc < 4; sc++)
        for (int r = 0; r < 2; r++)
          for (int p = 2; p < 4; p++)
            access(mk_base(BA, 2'(p), 3'b001, 1'b1), mk_opt(17'h1FFFF, 2'(ac), 4'(sc), 1'b0),
                   {BA, 10'h000, 5'(ac * 8 + sc * 3 + r * 5 + p)}, 1'(r), 0, "sweep");
    access(mk_base(BA, 2'b10, 3'b001, 1'b1), mk_opt(17'h1FFFF, 2'b10, 4'd5, 1'b0),
           {BA, 15'h0006}, 1'b0, 0, "R6 five waits");
    access(mk_base(BA, 2'b10, 3'b001, 1'b1), mk_opt(17'h1FFFF, 2'b11, 4'd15, 1'b0),
           {BA, 15'h001F}, 1'b1, 0, "R6 max waits");
    for (int p = 0; p < 2; p++)
      access(mk_base(BA, 2'(p), 3'b001, 1'b1), mk_opt(17'h1FFFF, 2'b00, 4'd0, 1'b0),
             {BA, 15'h0015}, 1'b1, 0, "R10 byte port");

    // decode
    access(mk_base(BA, 2'b10, 3'b001, 1'b0), mk_opt(17'h1FFFF, 2'b00, 4'd0, 1'b0),
           {BA, 15'h0}, 1'b1, 0, "R2 invalid");
    for (int m = 0; m < 8; m++)
      access(mk_base(BA, 2'b10, 3'(m), 1'b1), mk_opt(17'h1FFFF, 2'b00, 4'd0, 1'b0),
             {BA, 15'h2}, 1'b0, 0, "R3 ms sweep");
    access(mk_base(BA, 2'b10, 3'b001, 1'b1), mk_opt(17'h1FFFF, 2'b00, 4'd0, 1'b0),
           {BA ^ 17'h00001, 15'h0}, 1'b1, 0, "R2 lsb miss");
    access(mk_base(BA, 2'b10, 3'b001, 1'b1), mk_opt(17'h1FFFE, 2'b00, 4'd0, 1'b0),
           {BA ^ 17'h00001, 15'h0}, 1'b1, 0, "R2 lsb masked");
    access(mk_base(BA, 2'b10, 3'b001, 1'b1), mk_opt(17'h0FFFF, 2'b00, 4'd0, 1'b0),
           {BA ^ 17'h10000, 15'h4}, 1'b0, 0, "R2 msb masked");
    access(mk_base(BA, 2'b10, 3'b001, 1'b1), mk_opt(17'h0FFFF, 2'b00, 4'd0, 1'b0),
           {BA ^ 17'h08000, 15'h4}, 1'b0, 0, "R2 bit15 miss");
    access(mk_base(BA, 2'b10, 3'b001, 1'b1), mk_opt(17'h00000, 2'b00, 4'd0, 1'b0),
           32'h0000_1234, 1'b1, 0, "R2 zero mask");

    // acknowledge handling
    access(mk_base(BA, 2'b10, 3'b001, 1'b1), mk_opt(17'h1FFFF, 2'b11, 4'd3, 1'b0),
           {BA, 15'h8}, 1'b1, 2, "R8 early ack");
    access(mk_base(BA, 2'b10, 3'b001, 1'b1), mk_opt(17'h1FFFF, 2'b10, 4'd1, 1'b0),
           {BA, 15'hA}, 1'b0, 4, "R8 mid ack");
    access(mk_base(BA, 2'b10, 3'b001, 1'b1), mk_opt(17'h1FFFF, 2'b11, 4'd0, 1'b1),
           {BA, 15'hC}, 1'b1, 10, "R9 late ack");
    access(mk_base(BA, 2'b11, 3'b001, 1'b1), mk_opt(17'h1FFFF, 2'b11, 4'd0, 1'b1),
           {BA, 15'hE}, 1'b0, 1, "R9 ack in setup");
    access(mk_base(BA, 2'b10, 3'b001, 1'b1), mk_opt(17'h1FFFF, 2'b00, 4'd0, 1'b1),
           {BA, 15'h2}, 1'b1, 1, "R9 ack at once");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule